// File: doc/BRIEF.md
# Lockstep Fail-Fast Output Checker

This block sits between two identical processor cores that execute in lockstep and the buses those cores drive. Every cycle it compares the complete output bundle of both copies (address, data and all strobes) bit for bit. While the copies agree, the bundle from copy A is forwarded unchanged to every redundant bus port. The first time they disagree, all ports are forced to a fixed idle pattern with every strobe inactive in that same cycle. A sticky fault flag is also set, and it keeps the module silent until reset. A faulty module therefore stops instead of passing corrupt values to its backup or to either side of a dual bus.

A test hook can invert any single bit of copy B's bundle before the comparison. This proves that the comparator and the gating respond. Selecting a bit index past the end of the bundle leaves the hook inert.

Top module: `lockstep_guard`

## Requirements
- R1: While `halt` is 0, every bus port carries copy A's address, data and strobes in the same cycle.
- R2: A difference in any single bit of address, data or strobes between the two copies raises `halt` in that same cycle. Every port then drives address `IDLE_ADDR`, data `IDLE_DATA` and all strobes 0.
- R3: `fault_flag` becomes 1 at the first rising clock edge after a mismatch cycle. It stays 1 until `rst_n` is driven low, even when the copies agree again.
- R4: While `fault_flag` is 1, every port drives the idle pattern whatever the inputs are.
- R5: While `rst_n` is low, `fault_flag` is 0. After reset, matching copies pass straight through.
- R6: With `inj_en` at 1, bit `inj_sel` of copy B's bundle is inverted before the comparison. Bundle bit order: bits 0..ADDR_W-1 are the address, the next DATA_W bits are data, and the top STB_W bits are strobes.
- R7: A value of `inj_sel` at or above ADDR_W+DATA_W+STB_W has no effect: `halt` stays 0 and the outputs pass through.
- R8: All NUM_PORTS bus ports carry identical values at all times.
- R9: `halt` is 1 exactly when `fault_flag` is 1 or the copies currently disagree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only way to clear the fault |
| a_addr | input | ADDR_W | Copy A address |
| a_data | input | DATA_W | Copy A data |
| a_stb | input | STB_W | Copy A strobes and enables |
| b_addr | input | ADDR_W | Copy B address |
| b_data | input | DATA_W | Copy B data |
| b_stb | input | STB_W | Copy B strobes and enables |
| inj_en | input | 1 | Enables single-bit corruption of copy B |
| inj_sel | input | SEL_W | Index of the bit to corrupt |
| bus_addr | output | NUM_PORTS*ADDR_W | Gated address, one slice per port |
| bus_data | output | NUM_PORTS*DATA_W | Gated data, one slice per port |
| bus_stb | output | NUM_PORTS*STB_W | Gated strobes, one slice per port |
| halt | output | 1 | Stop indication: sticky fault or current mismatch |
| fault_flag | output | 1 | Sticky fault flag, cleared only by reset |

## Verification
The assertions assume that both copies' bundles, `inj_en` and `inj_sel` are settled at every rising clock edge, and that the block starts with reset asserted. The comparison is purely combinational, so a value that is changing at the edge could latch a fault that no real disagreement caused. The bench therefore changes every input on the falling edge only, and it holds reset low through the first rising edges. It samples the gated ports a short delay after each change and before the next rising edge.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

   typedef enum logic [0:0] {
      CMP_FLAT   = 1'b0,
      CMP_SLICED = 1'b1
   } cmp_style_e;

   function automatic int bundle_width(input int aw, input int dw, input int sw);
      return aw + dw + sw;
   endfunction

   function automatic int sel_width(input int w);
      return $clog2(w) + 1;
   endfunction

endpackage

// File: rtl/lsg_inject.sv
module lsg_inject #(
   parameter int W     = 8,
   parameter int SEL_W = 4
) (
   input  logic [W-1:0]     vec_in,
   input  logic             inj_en,
   input  logic [SEL_W-1:0] inj_sel,
   output logic [W-1:0]     vec_out
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign vec_out[i] = vec_in[i] ^ (inj_en && (inj_sel == SEL_W'(i)));
   end
endmodule

// File: rtl/lsg_compare.sv
module lsg_compare #(
   parameter int                  W       = 8,
   parameter int                  SLICE_W = 8,
   parameter lsg_pkg::cmp_style_e STYLE   = lsg_pkg::CMP_SLICED
) (
   input  logic [W-1:0] vec_a,
   input  logic [W-1:0] vec_b,
   output logic         mismatch
);
   localparam int NSLICE = (W + SLICE_W - 1) / SLICE_W;
   localparam int PAD_W  = NSLICE * SLICE_W;

   if (STYLE == lsg_pkg::CMP_FLAT) begin : g_flat
      assign mismatch = |(vec_a ^ vec_b);
   end else begin : g_sliced
      logic [PAD_W-1:0]  diff_pad;
      logic [NSLICE-1:0] slice_hit;
      assign diff_pad = PAD_W'(vec_a ^ vec_b);
      for (genvar s = 0; s < NSLICE; s++) begin : g_slice
         assign slice_hit[s] = |diff_pad[s*SLICE_W +: SLICE_W];
      end
      assign mismatch = |slice_hit;
   end
endmodule

// File: rtl/lsg_fault_latch.sv
module lsg_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic mismatch,
   output logic fault_q,
   output logic halt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fault_q <= 1'b0;
      else if (mismatch) fault_q <= 1'b1;
   end
   assign halt = fault_q | mismatch;
endmodule

// File: rtl/lsg_out_gate.sv
module lsg_out_gate #(
   parameter int                NUM_PORTS = 2,
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter int                STB_W     = 3,
   parameter logic [ADDR_W-1:0] IDLE_ADDR = '0,
   parameter logic [DATA_W-1:0] IDLE_DATA = '0
) (
   input  logic                          halt,
   input  logic [ADDR_W-1:0]             src_addr,
   input  logic [DATA_W-1:0]             src_data,
   input  logic [STB_W-1:0]              src_stb,
   output logic [NUM_PORTS*ADDR_W-1:0]   bus_addr,
   output logic [NUM_PORTS*DATA_W-1:0]   bus_data,
   output logic [NUM_PORTS*STB_W-1:0]    bus_stb
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign bus_addr[p*ADDR_W +: ADDR_W] = halt ? IDLE_ADDR : src_addr;
      assign bus_data[p*DATA_W +: DATA_W] = halt ? IDLE_DATA : src_data;
      assign bus_stb [p*STB_W  +: STB_W ] = halt ? '0        : src_stb;
   end
endmodule

// File: rtl/lockstep_guard.sv
module lockstep_guard #(
   parameter int                  ADDR_W    = 16,
   parameter int                  DATA_W    = 16,
   parameter int                  STB_W     = 3,
   parameter int                  NUM_PORTS = 2,
   parameter int                  SLICE_W   = 8,
   parameter lsg_pkg::cmp_style_e CMP_STYLE = lsg_pkg::CMP_SLICED,
   parameter logic [ADDR_W-1:0]   IDLE_ADDR = '0,
   parameter logic [DATA_W-1:0]   IDLE_DATA = '0,
   localparam int                 BUN_W     = lsg_pkg::bundle_width(ADDR_W, DATA_W, STB_W),
   localparam int                 SEL_W     = lsg_pkg::sel_width(BUN_W)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           a_addr,
   input  logic [DATA_W-1:0]           a_data,
   input  logic [STB_W-1:0]            a_stb,
   input  logic [ADDR_W-1:0]           b_addr,
   input  logic [DATA_W-1:0]           b_data,
   input  logic [STB_W-1:0]            b_stb,
   input  logic                        inj_en,
   input  logic [SEL_W-1:0]            inj_sel,
   output logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
   output logic [NUM_PORTS*DATA_W-1:0] bus_data,
   output logic [NUM_PORTS*STB_W-1:0]  bus_stb,
   output logic                        halt,
   output logic                        fault_flag
);
   if (ADDR_W < 1 || DATA_W < 1 || STB_W < 1) begin : g_bad_width
      $error("lockstep_guard: bundle field widths must be at least 1");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("lockstep_guard: NUM_PORTS must be at least 1");
   end
   if (SLICE_W < 1 || SLICE_W > BUN_W) begin : g_bad_slice
      $error("lockstep_guard: SLICE_W must lie in 1..bundle width");
   end

   logic [BUN_W-1:0] vec_a;
   logic [BUN_W-1:0] vec_b_raw;
   logic [BUN_W-1:0] vec_b;
   logic             mismatch;

   assign vec_a     = {a_stb, a_data, a_addr};
   assign vec_b_raw = {b_stb, b_data, b_addr};

   lsg_inject #(.W(BUN_W), .SEL_W(SEL_W)) u_inject (
      .vec_in  (vec_b_raw),
      .inj_en  (inj_en),
      .inj_sel (inj_sel),
      .vec_out (vec_b)
   );

   lsg_compare #(.W(BUN_W), .SLICE_W(SLICE_W), .STYLE(CMP_STYLE)) u_compare (
      .vec_a    (vec_a),
      .vec_b    (vec_b),
      .mismatch (mismatch)
   );

   lsg_fault_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .mismatch (mismatch),
      .fault_q  (fault_flag),
      .halt     (halt)
   );

   lsg_out_gate #(
      .NUM_PORTS (NUM_PORTS),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .STB_W     (STB_W),
      .IDLE_ADDR (IDLE_ADDR),
      .IDLE_DATA (IDLE_DATA)
   ) u_gate (
      .halt     (halt),
      .src_addr (a_addr),
      .src_data (a_data),
      .src_stb  (a_stb),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .bus_stb  (bus_stb)
   );
endmodule

// File: rtl/lsg_checker.sv
module lsg_checker #(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter int                STB_W     = 3,
   parameter int                NUM_PORTS = 2,
   parameter logic [ADDR_W-1:0] IDLE_ADDR = '0,
   parameter logic [DATA_W-1:0] IDLE_DATA = '0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           a_addr,
   input logic [DATA_W-1:0]           a_data,
   input logic [STB_W-1:0]            a_stb,
   input logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
   input logic [NUM_PORTS*DATA_W-1:0] bus_data,
   input logic [NUM_PORTS*STB_W-1:0]  bus_stb,
   input logic                        halt,
   input logic                        fault_flag
);
   // R1: pass-through while not halted
   p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !halt |-> (bus_addr[ADDR_W-1:0] == a_addr && bus_data[DATA_W-1:0] == a_data
                 && bus_stb[STB_W-1:0] == a_stb));

   // R2: halted port 0 is idle
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> (bus_stb[STB_W-1:0] == '0 && bus_addr[ADDR_W-1:0] == IDLE_ADDR
                && bus_data[DATA_W-1:0] == IDLE_DATA));

   // R3: a halt cycle leaves the flag set
   p_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> fault_flag);

   // R3: flag never drops without reset
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |=> fault_flag);

   // R4: flag set means silent bus
   p_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> bus_stb[STB_W-1:0] == '0);

   // R9: flag implies halt
   p_flag_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> halt);

   // R8: every port mirrors port 0
   for (genvar p = 1; p < NUM_PORTS; p++) begin : g_ports
      p_ports_r8: assert property (@(posedge clk) disable iff (!rst_n)
         bus_addr[p*ADDR_W +: ADDR_W] == bus_addr[ADDR_W-1:0]
         && bus_data[p*DATA_W +: DATA_W] == bus_data[DATA_W-1:0]
         && bus_stb[p*STB_W +: STB_W] == bus_stb[STB_W-1:0]);
   end
endmodule

bind lockstep_guard lsg_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .STB_W     (STB_W),
   .NUM_PORTS (NUM_PORTS),
   .IDLE_ADDR (IDLE_ADDR),
   .IDLE_DATA (IDLE_DATA)
) u_lsg_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .a_addr     (a_addr),
   .a_data     (a_data),
   .a_stb      (a_stb),
   .bus_addr   (bus_addr),
   .bus_data   (bus_data),
   .bus_stb    (bus_stb),
   .halt       (halt),
   .fault_flag (fault_flag)
);

// File: tb/tb_lockstep_guard.sv
module tb_lockstep_guard;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int SW = 3;
   localparam int NP = 2;
   localparam int BW = AW + DW + SW;
   localparam int SELW = $clog2(BW) + 1;
   localparam logic [AW-1:0] IA = 16'hDEAD;
   localparam logic [DW-1:0] ID = 16'h0F0F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_data = '0, b_data = '0;
   logic [SW-1:0] a_stb = '0, b_stb = '0;
   logic inj_en = 1'b0;
   logic [SELW-1:0] inj_sel = '0;
   logic [NP*AW-1:0] bus_addr;
   logic [NP*DW-1:0] bus_data;
   logic [NP*SW-1:0] bus_stb;
   logic halt, fault_flag;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lockstep_guard #(
      .ADDR_W(AW), .DATA_W(DW), .STB_W(SW), .NUM_PORTS(NP),
      .IDLE_ADDR(IA), .IDLE_DATA(ID)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .a_addr(a_addr), .a_data(a_data), .a_stb(a_stb),
      .b_addr(b_addr), .b_data(b_data), .b_stb(b_stb),
      .inj_en(inj_en), .inj_sel(inj_sel),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_stb(bus_stb),
      .halt(halt), .fault_flag(fault_flag)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_bus(input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                          input logic [SW-1:0] es, input string req);
      for (int p = 0; p < NP; p++) begin
         chk(bus_addr[p*AW +: AW] == ea, req, $sformatf("port%0d addr", p),
             64'(bus_addr[p*AW +: AW]), 64'(ea));
         chk(bus_data[p*DW +: DW] == ed, req, $sformatf("port%0d data", p),
             64'(bus_data[p*DW +: DW]), 64'(ed));
         chk(bus_stb[p*SW +: SW] == es, req, $sformatf("port%0d stb", p),
             64'(bus_stb[p*SW +: SW]), 64'(es));
      end
   endtask

   task automatic drive(input logic [AW-1:0] ad, input logic [DW-1:0] da,
                        input logic [SW-1:0] st);
      a_addr = ad; b_addr = ad;
      a_data = da; b_data = da;
      a_stb  = st; b_stb  = st;
   endtask

   task automatic next_cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      inj_en = 1'b0; inj_sel = '0;
      drive('0, '0, '0);
      rst_n = 1'b0;
      next_cycle();
      next_cycle();
      rst_n = 1'b1;
      #1;
   endtask

   // R5: reset state and release
   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      drive(16'h1234, 16'h5678, 3'b101);
      b_data = 16'h5679;
      next_cycle();
      #1;
      chk(fault_flag == 1'b0, "R5", "fault during reset", 64'(fault_flag), 64'd0);
      drive(16'h1234, 16'h5678, 3'b101);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(fault_flag == 1'b0, "R5", "fault after release", 64'(fault_flag), 64'd0);
      chk_bus(16'h1234, 16'h5678, 3'b101, "R5");
   endtask

   // R1, R8, R9: matching copies pass through
   task automatic t_pass();
      logic [AW-1:0] pa [3] = '{16'hFFFF, 16'hAAAA, 16'h0001};
      logic [DW-1:0] pd [3] = '{16'hFFFF, 16'h5555, 16'h8000};
      logic [SW-1:0] ps [3] = '{3'b111, 3'b010, 3'b100};
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         drive(pa[k], pd[k], ps[k]);
         #1;
         chk(halt == 1'b0, "R9", "halt on match", 64'(halt), 64'd0);
         chk_bus(pa[k], pd[k], ps[k], "R1");
      end
      next_cycle();
      chk(fault_flag == 1'b0, "R1", "fault after matches", 64'(fault_flag), 64'd0);
   endtask

   // R2, R3, R4, R9: natural mismatch and stickiness
   task automatic t_mismatch(input int field);
      do_reset();
      @(negedge clk);
      drive(16'h0C0C, 16'h3C3C, 3'b011);
      if (field == 0) b_addr[7] = ~b_addr[7];
      else if (field == 1) b_data[0] = ~b_data[0];
      else b_stb[2] = ~b_stb[2];
      #1;
      chk(halt == 1'b1, "R2", $sformatf("halt same cycle f%0d", field), 64'(halt), 64'd1);
      chk(fault_flag == 1'b0, "R3", "flag not yet set", 64'(fault_flag), 64'd0);
      chk_bus(IA, ID, '0, "R2");
      next_cycle();
      chk(fault_flag == 1'b1, "R3", "flag after edge", 64'(fault_flag), 64'd1);
      drive(16'h7777, 16'h1111, 3'b111);
      #1;
      for (int c = 0; c < 3; c++) begin
         chk(fault_flag == 1'b1, "R3", "flag sticky", 64'(fault_flag), 64'd1);
         chk(halt == 1'b1, "R9", "halt held by flag", 64'(halt), 64'd1);
         chk_bus(IA, ID, '0, "R4");
         next_cycle();
         #1;
      end
   endtask

   // R6: injection into each field
   task automatic t_inject(input int idx);
      do_reset();
      @(negedge clk);
      drive(16'h4321, 16'h8765, 3'b110);
      inj_sel = SELW'(idx);
      inj_en = 1'b1;
      #1;
      chk(halt == 1'b1, "R6", $sformatf("inject bit %0d", idx), 64'(halt), 64'd1);
      chk_bus(IA, ID, '0, "R6");
      next_cycle();
      inj_en = 1'b0;
      #1;
      chk(fault_flag == 1'b1, "R6", "inject latched", 64'(fault_flag), 64'd1);
   endtask

   // R7: out-of-range selection is inert
   task automatic t_inject_oob(input int idx);
      do_reset();
      @(negedge clk);
      drive(16'hBEEF, 16'hCAFE, 3'b001);
      inj_sel = SELW'(idx);
      inj_en = 1'b1;
      #1;
      chk(halt == 1'b0, "R7", $sformatf("oob sel %0d", idx), 64'(halt), 64'd0);
      chk_bus(16'hBEEF, 16'hCAFE, 3'b001, "R7");
      next_cycle();
      chk(fault_flag == 1'b0, "R7", "oob no latch", 64'(fault_flag), 64'd0);
      inj_en = 1'b0;
   endtask

   initial begin
      t_reset();
      t_pass();
      t_mismatch(0);
      t_mismatch(1);
      t_mismatch(2);
      t_inject(0);
      t_inject(AW + 3);
      t_inject(AW + DW);
      t_inject(BW - 1);
      t_inject_oob(BW);
      t_inject_oob((1 << SELW) - 1);
      do_reset();
      chk(fault_flag == 1'b0, "R3", "reset clears flag", 64'(fault_flag), 64'd0);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule